// File: doc/BRIEF.md
# Binary-Coded Dual-Tone Keypad Synthesizer

This block turns a 4-bit key code into a digital dual-tone keypad signal. The code is captured when the tone-enable input goes high. From then on, one divider chain for the row (low-group) tone and one for the column (high-group) tone each step a 28-entry sine sequence. The two sine values are added into a signed sample word. The column tone gets 5/4 gain before the addition. When tone-enable drops, the block goes quiet and raises mute.

Divide ratios are worked out at elaboration from the reference clock parameter, 3.579545 MHz by default. With that default every tone lands within 0.64 % of its nominal frequency. A test mode produces only one tone, and a select input picks which group that is. The sample word is meant to feed a downstream DAC or a digital consumer. A strobe marks each cycle in which a new sample takes effect.

Top module: `dtmf_synth`

## Requirements
- R1: `data` is captured only in the cycle where `tone_enable` is high and was low in the previous cycle. Changes to `data` at any other time have no effect on the output samples.
- R2: While `tone_enable` is low, `sample` is 0 and `sample_valid` is 0. Each new burst restarts both sine sequences at step 0.
- R3: `mute` is 1 from reset. It goes to 0 two clock edges after `tone_enable` is sampled high, and returns to 1 two edges after `tone_enable` is sampled low.
- R4: Key codes map to keypad positions as follows. Rows are 697, 770, 852 and 941 Hz; columns are 1209, 1336, 1477 and 1633 Hz, indexed 0 to 3. Code 1–9 gives row (code-1)/3 and column (code-1)%3. Code 10 gives row 3, column 1. Code 11 gives row 3, column 0. Code 12 gives row 3, column 2. Codes 13, 14 and 15 give rows 0, 1 and 2 in column 3. Code 0 gives row 3, column 3.
- R5: Each tone advances one sine step every R clock cycles, where R = round(REF_HZ / (28·f)). The first step of a burst takes effect R cycles after the capture edge. Its sample appears one edge later.
- R6: Step k of a sine sequence has the value round(127·sin(2πk/28)), for k from 0 to 27. The sequence wraps from 27 back to 0.
- R7: In dual-tone mode, `sample` = L + H + floor(H/4), where L is the row sine value and H is the column sine value. The result saturates to a signed `OUT_W`-bit range.
- R8: When `single_tone_n` is 0, only one tone is produced. `group_sel` = 1 gives the column tone, with its 5/4 gain. `group_sel` = 0 gives the row tone. The other term is zero.
- R9: `sample_valid` pulses for one cycle each time an enabled tone steps, one edge after the step. It is high only while `mute` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| data | input | 4 | Binary key code |
| tone_enable | input | 1 | High to generate tones; the rising edge captures `data` |
| single_tone_n | input | 1 | Low selects single-tone test mode |
| group_sel | input | 1 | In single-tone mode: 1 gives the column tone, 0 gives the row tone |
| sample | output | OUT_W | Signed summed sample |
| sample_valid | output | 1 | Strobe marking a new sample step |
| mute | output | 1 | High while no tone is generated |

## Verification
The assertions assume that `tone_enable` is a level held for many cycles. They also assume that `single_tone_n` and `group_sel` stay constant during a burst, so the mode gating cannot change between a step and its sample. The stimulus changes those mode inputs only while the block is idle. It holds each burst for thousands of cycles, which covers a full row-tone period in at least one burst. It also changes `data` in the middle of a burst, to confirm that the captured code holds.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int STEPS  = 28;
  localparam int STEP_W = $clog2(STEPS);
  localparam int SINE_W = 8;

  typedef logic [1:0] sel_t;
  typedef struct packed {
    sel_t row;
    sel_t col;
  } tone_pair_t;

  function automatic int freq_hz(bit hi_grp, int k);
    int f;
    case (k)
      0:       f = hi_grp ? 1209 : 697;
      1:       f = hi_grp ? 1336 : 770;
      2:       f = hi_grp ? 1477 : 852;
      default: f = hi_grp ? 1633 : 941;
    endcase
    return f;
  endfunction

  function automatic int div_ratio(int ref_hz, int f);
    return (ref_hz + (STEPS / 2) * f) / (STEPS * f);
  endfunction

  function automatic tone_pair_t decode_key(logic [3:0] c);
    tone_pair_t p;
    case (c)
      4'd1:  p = '{2'd0, 2'd0};
      4'd2:  p = '{2'd0, 2'd1};
      4'd3:  p = '{2'd0, 2'd2};
      4'd4:  p = '{2'd1, 2'd0};
      4'd5:  p = '{2'd1, 2'd1};
      4'd6:  p = '{2'd1, 2'd2};
      4'd7:  p = '{2'd2, 2'd0};
      4'd8:  p = '{2'd2, 2'd1};
      4'd9:  p = '{2'd2, 2'd2};
      4'd10: p = '{2'd3, 2'd1};
      4'd11: p = '{2'd3, 2'd0};
      4'd12: p = '{2'd3, 2'd2};
      4'd13: p = '{2'd0, 2'd3};
      4'd14: p = '{2'd1, 2'd3};
      4'd15: p = '{2'd2, 2'd3};
      default: p = '{2'd3, 2'd3};
    endcase
    return p;
  endfunction

  // Half-wave symmetric table: only a quarter wave is stored.
  function automatic logic signed [SINE_W-1:0] sine_at(logic [STEP_W-1:0] k);
    int idx;
    int mag;
    bit neg;
    neg = (int'(k) >= STEPS / 2);
    idx = neg ? int'(k) - STEPS / 2 : int'(k);
    if (idx > STEPS / 4) idx = STEPS / 2 - idx;
    case (idx)
      0:       mag = 0;
      1:       mag = 28;
      2:       mag = 55;
      3:       mag = 79;
      4:       mag = 99;
      5:       mag = 114;
      6:       mag = 124;
      default: mag = 127;
    endcase
    return neg ? SINE_W'(-mag) : SINE_W'(mag);
  endfunction
endpackage

// File: rtl/dtmf_key_latch.sv
module dtmf_key_latch
  import dtmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tone_enable,
  input  logic [3:0] data,
  output logic       active,
  output tone_pair_t pair
);
  logic rise;
  assign rise = tone_enable & ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pair   <= '0;
    end else begin
      active <= tone_enable;
      if (rise) pair <= decode_key(data);
    end
  end
endmodule

// File: rtl/dtmf_tone_ch.sv
module dtmf_tone_ch
  import dtmf_pkg::*;
#(
  parameter int REF_HZ   = 3579545,
  parameter bit HIGH_GRP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  sel_t              sel,
  output logic [STEP_W-1:0] step,
  output logic              tick
);
  localparam int CNT_W = $clog2(div_ratio(REF_HZ, freq_hz(HIGH_GRP, 0)) + 1);

  logic [CNT_W-1:0] limit_lut [4];
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  for (genvar k = 0; k < 4; k++) begin : g_lut
    assign limit_lut[k] = CNT_W'(div_ratio(REF_HZ, freq_hz(HIGH_GRP, k)) - 1);
  end

  assign wrap = (cnt == limit_lut[sel]);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      step <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap) begin
        cnt  <= '0;
        step <= (step == STEP_W'(STEPS - 1)) ? '0 : step + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtmf_mixer.sv
module dtmf_mixer
  import dtmf_pkg::*;
#(
  parameter int OUT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [STEP_W-1:0] lo_step,
  input  logic [STEP_W-1:0] hi_step,
  input  logic              lo_tick,
  input  logic              hi_tick,
  input  logic              use_lo,
  input  logic              use_hi,
  output logic [OUT_W-1:0]  sample,
  output logic              sample_valid,
  output logic              mute
);
  localparam int SUM_W = (OUT_W + 1 > SINE_W + 3) ? OUT_W + 1 : SINE_W + 3;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - 1;

  logic signed [SINE_W-1:0] lo_v, hi_v;
  logic signed [SUM_W-1:0]  lo_x, hi_x, sum;
  logic [OUT_W-1:0]         sat;

  always_comb begin
    lo_v = use_lo ? sine_at(lo_step) : '0;
    hi_v = use_hi ? sine_at(hi_step) : '0;
    lo_x = {{(SUM_W - SINE_W){lo_v[SINE_W-1]}}, lo_v};
    hi_x = {{(SUM_W - SINE_W){hi_v[SINE_W-1]}}, hi_v};
    sum  = lo_x + hi_x + (hi_x >>> 2);
    if (sum > SAT_HI)      sat = SAT_HI[OUT_W-1:0];
    else if (sum < SAT_LO) sat = SAT_LO[OUT_W-1:0];
    else                   sat = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample       <= '0;
      sample_valid <= 1'b0;
      mute         <= 1'b1;
    end else begin
      mute         <= ~active;
      sample       <= active ? sat : '0;
      sample_valid <= active & ((lo_tick & use_lo) | (hi_tick & use_hi));
    end
  end
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_pkg::*;
#(
  parameter int REF_HZ = 3579545,
  parameter int OUT_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       data,
  input  logic             tone_enable,
  input  logic             single_tone_n,
  input  logic             group_sel,
  output logic [OUT_W-1:0] sample,
  output logic             sample_valid,
  output logic             mute
);
  logic              active;
  tone_pair_t        key_pair;
  logic [STEP_W-1:0] steps [2];
  logic [1:0]        ticks;
  logic              use_lo, use_hi;

  assign use_lo = single_tone_n | ~group_sel;
  assign use_hi = single_tone_n | group_sel;

  dtmf_key_latch u_latch (
    .clk(clk), .rst(rst), .tone_enable(tone_enable), .data(data),
    .active(active), .pair(key_pair)
  );

  for (genvar g = 0; g < 2; g++) begin : g_grp
    dtmf_tone_ch #(.REF_HZ(REF_HZ), .HIGH_GRP(g == 1)) u_ch (
      .clk(clk), .rst(rst), .run(active),
      .sel((g == 0) ? key_pair.row : key_pair.col),
      .step(steps[g]), .tick(ticks[g])
    );
  end

  dtmf_mixer #(.OUT_W(OUT_W)) u_mix (
    .clk(clk), .rst(rst), .active(active),
    .lo_step(steps[0]), .hi_step(steps[1]),
    .lo_tick(ticks[0]), .hi_tick(ticks[1]),
    .use_lo(use_lo), .use_hi(use_hi),
    .sample(sample), .sample_valid(sample_valid), .mute(mute)
  );
endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk
  import dtmf_pkg::*;
#(
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             tone_enable,
  input logic             active,
  input tone_pair_t       pair_q,
  input logic [OUT_W-1:0] sample,
  input logic             sample_valid,
  input logic             mute
);
  assert_code_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (active && tone_enable) |=> $stable(pair_q));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    mute |-> (sample == '0 && !sample_valid));

  assert_mute_set_R3: assert property (@(posedge clk) disable iff (rst)
    !tone_enable |-> ##2 mute);

  assert_mute_clear_R3: assert property (@(posedge clk) disable iff (rst)
    tone_enable |-> ##2 !mute);

  assert_valid_unmuted_R9: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> !mute);
endmodule

bind dtmf_synth dtmf_synth_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .tone_enable(tone_enable), .active(active),
  .pair_q(key_pair), .sample(sample), .sample_valid(sample_valid), .mute(mute)
);

// File: tb/test_dtmf_synth.sv
module test_dtmf_synth;
  localparam int REF   = 3579545;
  localparam int OUT_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] data = 4'd0;
  logic tone_enable = 1'b0;
  logic single_tone_n = 1'b1;
  logic group_sel = 1'b1;
  logic [OUT_W-1:0] sample;
  logic sample_valid, mute;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string cur_tag = "R9";
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtmf_synth #(.REF_HZ(REF), .OUT_W(OUT_W)) i_dtmf_synth (
    .clk(clk), .rst(rst), .data(data), .tone_enable(tone_enable),
    .single_tone_n(single_tone_n), .group_sel(group_sel),
    .sample(sample), .sample_valid(sample_valid), .mute(mute)
  );

  int sine_tab[28] = '{0, 28, 55, 79, 99, 114, 124, 127, 124, 114, 99, 79, 55, 28,
                       0, -28, -55, -79, -99, -114, -124, -127, -124, -114, -99, -79, -55, -28};
  int row_hz[4] = '{697, 770, 852, 941};
  int col_hz[4] = '{1209, 1336, 1477, 1633};
  int key_row[16] = '{3, 0, 0, 0, 1, 1, 1, 2, 2, 2, 3, 3, 3, 0, 1, 2};
  int key_col[16] = '{3, 0, 1, 2, 0, 1, 2, 0, 1, 2, 1, 0, 2, 3, 3, 3};

  function automatic int ratio_of(int f);
    return (REF + 14 * f) / (28 * f);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as valid samples emerge
  always @(negedge clk) begin
    if (!rst && sample_valid) begin
      if (exp_q.size() == 0)
        check(1'b0, {cur_tag, " R9 unexpected valid"}, $signed(sample), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check($signed(sample) == e, {cur_tag, " sample"}, $signed(sample), e);
      end
    end
  end

  task automatic burst(int code, int len, bit single, bit gsel, bit scramble, string tag);
    int rl, rh, first, lo, hi, v;
    bit en_lo, en_hi;
    @(negedge clk);
    cur_tag = tag;
    data = 4'(code);
    single_tone_n = ~single;
    group_sel = gsel;
    rl = ratio_of(row_hz[key_row[code]]);
    rh = ratio_of(col_hz[key_col[code]]);
    en_lo = !single || !gsel;
    en_hi = !single || gsel;
    for (int t = 1; t <= len; t++) begin
      if ((en_lo && t % rl == 0) || (en_hi && t % rh == 0)) begin
        lo = en_lo ? sine_tab[(t / rl) % 28] : 0;
        hi = en_hi ? sine_tab[(t / rh) % 28] : 0;
        v = lo + hi + (hi >>> 2);
        if (v > 511) v = 511;
        if (v < -512) v = -512;
        exp_q.push_back(v);
      end
    end
    tone_enable = 1'b1;
    first = -1;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      if (i == 40 && scramble) data = ~data;
      if (i == 5) check(mute == 1'b0, "R3 mute released", mute, 0);
      if (sample_valid && first < 0) first = i;
    end
    // R5: first step after min(enabled ratio) cycles, sample one edge later
    v = (en_lo && (!en_hi || rl < rh)) ? rl : rh;
    check(first == v + 1, {tag, " R5 first step cycle"}, first, v + 1);
    tone_enable = 1'b0;
    if (scramble) data = 4'd5;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {tag, " R9 step count"}, exp_q.size(), 0);
    check(sample == '0 && !sample_valid, "R2 idle output", $signed(sample), 0);
    check(mute == 1'b1, "R3 mute set", mute, 1);
    exp_q.delete();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sample == '0, "R2 reset sample", $signed(sample), 0);
    check(sample_valid == 1'b0, "R2 reset valid", sample_valid, 0);
    check(mute == 1'b1, "R3 reset mute", mute, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    data = 4'd9;
    repeat (3) @(negedge clk);
    burst(1, 5300, 1'b0, 1'b1, 1'b0, "R6/R7");
    burst(0, 2500, 1'b0, 1'b1, 1'b1, "R1/R4");
    burst(0, 1200, 1'b0, 1'b1, 1'b0, "R2 restart");
    burst(11, 2500, 1'b1, 1'b1, 1'b0, "R8 high");
    burst(12, 3000, 1'b1, 1'b0, 1'b0, "R8 low");
    burst(10, 1500, 1'b0, 1'b1, 1'b0, "R4 key0");
    burst(14, 1500, 1'b0, 1'b1, 1'b1, "R4 keyB");
    burst(8, 1500, 1'b0, 1'b1, 1'b0, "R4 key8");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule